// File: doc/BRIEF.md
# Sixteen-Channel TDM Serial Transmitter

This block turns sixteen 16-bit audio channels into one time-division-multiplexed serial stream. It runs entirely on the incoming master clock. The bit clock is that master clock divided by two, and the block drives it, a one-bit frame sync and the serial data line itself. A frame is eight 32-bit slots, 256 bit periods in all. Each slot carries two channels: the even channel in its upper half and the odd channel in its lower half. Bits leave most significant first.

Upstream logic offers a full set of sixteen samples with a valid/ready handshake. The block accepts one set per frame, at the frame boundary, and copies it into a frame-wide shift register. Later changes on the sample bus therefore cannot disturb the frame being sent. If no set is offered at a boundary, the block sends a frame of zeros and raises a sticky underrun flag. A one-cycle frame-start strobe tells upstream logic when the new frame has begun.

Top module: `tdm16_tx`

## Requirements
- R1: `bclk` is low while reset is held. After reset it toggles on every master clock cycle, so it runs at half the master clock rate.
- R2: `sdata` and `fsync` change only on the master clock edge where `bclk` goes from high to low. A receiver samples them on the rising edge of `bclk`.
- R3: `fsync` is active high and lasts exactly one bit period, the last bit of each 256-bit frame. It is therefore high once every 256 bit periods, and in the first bit period after reset.
- R4: Frame bit j, counted from 0 at the first bit after `fsync`, is bit 15-(j mod 16) of channel floor(j/16). Channel c occupies `s_samples[16c+15:16c]`. Slot k therefore holds channel 2k in its upper 16 bits and channel 2k+1 in its lower 16 bits.
- R5: Within each channel the most significant bit is sent first. The first 16 bits of a frame equal channel 0 read from bit 15 down to bit 0.
- R6: `s_ready` is high for exactly one master cycle per frame: the last cycle of the frame's final bit period. A sample set is taken when `s_valid` and `s_ready` are both high.
- R7: If `s_valid` is low while `s_ready` is high, every bit of the following frame is zero.
- R8: `underrun` is set by a boundary with no valid set and stays set until `underrun_clr` is high. When both happen in the same cycle, setting wins.
- R9: Changes on `s_samples` after a set has been taken do not affect the frame being sent.
- R10: `frame_start` is high for one master cycle, in the cycle in which the first bit of slot 0 appears on `sdata`.
- R11: While reset is held, `bclk`, `sdata`, `fsync`, `s_ready`, `frame_start` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | A full sample set is present on `s_samples` |
| s_ready | output | 1 | The sample set is taken in this cycle if valid |
| s_samples | input | 256 | Sixteen 16-bit samples, channel c at bits 16c+15:16c |
| underrun_clr | input | 1 | Write-one-to-clear for `underrun` |
| bclk | output | 1 | Bit clock, master clock divided by two |
| fsync | output | 1 | Frame sync, high during the last bit of a frame |
| sdata | output | 1 | Serial TDM data, MSB first |
| frame_start | output | 1 | One-cycle pulse when slot 0 begins |
| underrun | output | 1 | Sticky flag: a frame was sent without data |

## Verification
The hardest case to reach from the ports is a clear request that lands in the same master cycle as a data-less frame boundary. That cycle lasts one master clock out of every 512. The bench's reference model predicts the boundary, so the stimulus waits for the negative edge just before it, drops `s_valid` and raises `underrun_clr` for that single cycle. The sample bus is also scrambled every few dozen cycles inside each frame, to show that only the values present at the boundary reach the line.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_NUM_CH   = 16;
  localparam int unsigned DEF_SLOT_W   = 32;

  // Bit-clock events seen from the master clock domain
  typedef struct packed {
    logic fall;  // bclk is high now and drops at the next edge
    logic rise;  // bclk is low now and rises at the next edge
  } bclk_evt_t;

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen
  import tdm_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output logic      bclk,
  output bclk_evt_t evt
);

  always_ff @(posedge clk) begin
    if (rst) bclk <= 1'b0;
    else     bclk <= ~bclk;
  end

  assign evt.fall = bclk;
  assign evt.rise = ~bclk;

  AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bclk != $past(bclk)));  // R1

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic boundary,
  output logic fsync,
  output logic frame_start
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(FRAME_BITS - 2);

  logic [CNT_W-1:0] bit_idx;

  // Boundary: the last master cycle of the frame's final bit
  assign boundary = adv && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx     <= PRE_LAST;
      fsync       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= boundary;
      if (adv) begin
        bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
        fsync   <= (bit_idx == PRE_LAST);
      end
    end
  end

  AST_FSYNC_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    fsync |-> (bit_idx == LAST));  // R3

  AST_FSTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);  // R10

endmodule

// File: rtl/tdm_pack.sv
module tdm_pack #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned SLOT_W   = 32
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic [NUM_CH*SAMPLE_W-1:0] frame
);

  localparam int unsigned CH_PER_SLOT = SLOT_W / SAMPLE_W;
  localparam int unsigned NUM_SLOTS   = NUM_CH / CH_PER_SLOT;
  localparam int unsigned FRAME_BITS  = NUM_CH * SAMPLE_W;

  // Slot 0 leaves first: it sits at the top of the frame vector.
  // Inside a slot the lower-numbered channel takes the upper bits.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar h = 0; h < CH_PER_SLOT; h++) begin : g_half
      localparam int unsigned CH  = s * CH_PER_SLOT + h;
      localparam int unsigned TOP = FRAME_BITS - 1 - s * SLOT_W - h * SAMPLE_W;
      assign frame[TOP -: SAMPLE_W] = samples[CH*SAMPLE_W +: SAMPLE_W];
    end
  end

endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_data,
  output logic                  sdata
);

  logic [FRAME_BITS-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      sdata  <= 1'b0;
    end else if (adv) begin
      if (load) begin
        sdata  <= load_data[FRAME_BITS-1];
        remain <= {load_data[FRAME_BITS-2:0], 1'b0};
      end else begin
        sdata  <= remain[FRAME_BITS-1];
        remain <= {remain[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/tdm16_tx.sv
module tdm16_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned NUM_CH   = DEF_NUM_CH,
  parameter int unsigned SLOT_W   = DEF_SLOT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] s_samples,
  input  logic                       underrun_clr,
  output logic                       bclk,
  output logic                       fsync,
  output logic                       sdata,
  output logic                       frame_start,
  output logic                       underrun
);

  localparam int unsigned FRAME_BITS = NUM_CH * SAMPLE_W;

  bclk_evt_t             evt;
  logic                  boundary;
  logic [FRAME_BITS-1:0] packed_frame;
  logic [FRAME_BITS-1:0] next_frame;

  tdm_bclk_gen u_bclk (
    .clk  (clk),
    .rst  (rst),
    .bclk (bclk),
    .evt  (evt)
  );

  tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .adv         (evt.fall),
    .boundary    (boundary),
    .fsync       (fsync),
    .frame_start (frame_start)
  );

  tdm_pack #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_pack (
    .samples (s_samples),
    .frame   (packed_frame)
  );

  // A missing set becomes a frame of zeros
  assign next_frame = s_valid ? packed_frame : '0;
  assign s_ready    = boundary;

  tdm_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .adv       (evt.fall),
    .load      (boundary),
    .load_data (next_frame),
    .sdata     (sdata)
  );

  always_ff @(posedge clk) begin
    if (rst)                      underrun <= 1'b0;
    else if (boundary && !s_valid) underrun <= 1'b1;
    else if (underrun_clr)        underrun <= 1'b0;
  end

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk));  // R2

  AST_FSYNC_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsync) |-> $fell(bclk));  // R2

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);  // R6

  AST_READY_BCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> bclk);  // R6

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(underrun) && !$past(underrun_clr)) |-> underrun);  // R8

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !s_valid) |=> underrun);  // R8

  AST_FSTART_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(s_ready));  // R10

endmodule

// File: tb/test_tdm16_tx.sv
module test_tdm16_tx;

  localparam int SW = 16;
  localparam int NC = 16;
  localparam int FB = NC * SW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic            s_valid;
  logic            clr;
  logic [FB-1:0]   s_samples;
  logic            s_ready, bclk, fsync, sdata, frame_start, underrun;

  tdm16_tx i_tdm16_tx (
    .clk          (clk),
    .rst          (rst),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_samples    (s_samples),
    .underrun_clr (clr),
    .bclk         (bclk),
    .fsync        (fsync),
    .sdata        (sdata),
    .frame_start  (frame_start),
    .underrun     (underrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_bclk, m_sdata, m_fs, m_fstart, m_under, m_zero, m_bnd, seen_edge;
  int        m_idx;
  bit        bitq[$];
  logic [15:0] m_ch0;

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      m_bclk = 0; m_idx = FB - 2; bitq.delete();
      m_sdata = 0; m_fs = 0; m_fstart = 0; m_under = 0; m_zero = 0;
    end else begin
      m_bnd    = m_bclk && (m_idx == FB - 1);
      m_fstart = m_bnd;
      if (clr) m_under = 0;
      if (m_bnd && !s_valid) m_under = 1;
      if (m_bclk) begin
        m_idx = (m_idx + 1) % FB;
        if (m_idx == 0) begin
          bitq.delete();
          m_zero = !s_valid;
          m_ch0  = s_valid ? s_samples[15:0] : 16'h0;
          for (int c = 0; c < NC; c++)
            for (int b = SW - 1; b >= 0; b--)
              bitq.push_back(s_valid ? s_samples[c*SW + b] : 1'b0);
        end
        m_sdata = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
        m_fs    = (m_idx == FB - 1);
      end
      m_bclk = !m_bclk;
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit        prev_ok, prev_bclk, prev_sd, prev_fs;
  logic [15:0] cap;
  int        ones;

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      chk("R1", "bclk", bclk, m_bclk);
      chk("R4 R9", "sdata", sdata, m_sdata);
      chk("R3", "fsync", fsync, m_fs);
      chk("R6", "s_ready", s_ready, (m_bclk && m_idx == FB - 1) ? 1 : 0);
      chk("R10", "frame_start", frame_start, m_fstart);
      chk("R8", "underrun", underrun, m_under);
      if (prev_ok && !rst && (sdata !== prev_sd || fsync !== prev_fs))
        chk("R2", "change only on bclk fall", (prev_bclk && !bclk) ? 1 : 0, 1);
      if (!rst && !m_bclk) begin
        cap = {cap[14:0], sdata};
        if (m_idx == 0) ones = 0;
        ones += sdata;
        if (m_idx == 15 && !m_zero) chk("R5", "first channel MSB first", cap, m_ch0);
        if (m_idx == FB - 1 && m_zero) chk("R7", "ones in empty frame", ones, 0);
      end
      prev_ok = 1; prev_bclk = bclk; prev_sd = sdata; prev_fs = fsync;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_boundary();
    do @(negedge clk); while (!(m_bclk && m_idx == FB - 1));
  endtask

  task automatic fill(input int kind);
    for (int c = 0; c < NC; c++) begin
      case (kind)
        0: s_samples[c*SW +: SW] = 16'(c * 16'h1111 + 16'h0102);
        1: s_samples[c*SW +: SW] = 16'hFFFF;
        2: s_samples[c*SW +: SW] = 16'(16'h0001 << c);
        default: s_samples[c*SW +: SW] = 16'($urandom);
      endcase
    end
  endtask

  task automatic run_frame(input bit valid, input int kind, input bit clr_mid);
    for (int k = 1; k < 500; k++) begin
      @(negedge clk);
      clr = (clr_mid && k == 200);
      if (k % 37 == 0) fill(3);  // R9: mid-frame disturbance
    end
    wait_boundary();
    s_valid = valid;
    fill(kind);
  endtask

  initial begin
    rst = 1; s_valid = 0; clr = 0; s_samples = '0;
    repeat (4) @(negedge clk);
    chk("R11", "bclk in reset", bclk, 0);
    chk("R11", "sdata in reset", sdata, 0);
    chk("R11", "fsync in reset", fsync, 0);
    chk("R11", "s_ready in reset", s_ready, 0);
    chk("R11", "frame_start in reset", frame_start, 0);
    chk("R11", "underrun in reset", underrun, 0);
    rst = 0;
    wait_boundary();
    s_valid = 1; fill(0);
    run_frame(1, 1, 0);   // all ones next
    run_frame(1, 3, 0);   // random next
    run_frame(0, 3, 0);   // R7 R8: underrun next
    run_frame(1, 3, 1);   // clear pulsed during the empty frame, data next
    run_frame(1, 2, 0);   // walking ones next
    // R8: clear and new underrun in the same cycle, set wins
    wait_boundary();
    s_valid = 0; clr = 1;
    @(negedge clk);
    clr = 0;
    run_frame(1, 3, 0);
    run_frame(1, 0, 0);
    run_frame(1, 1, 0);
    repeat (20) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule